// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects interrupt requests from a group of devices into one pending-request vector and drives a single upstream interrupt line. Each device sets its request bits by pulsing a post vector and drops them by pulsing a clear vector. Software reaches the block over a small synchronous register bus. It can write an inverted-sense mask, acknowledge one request by its index, read the pending vector, and use a second mask register that holds its value and has no other function.

The upstream line is the output of a registered interrupting flag. The flag changes only when something in the cycle calls for a change. Raising a request always raises the line, even when that request is masked. An acknowledge always drops the line. A mask write sets the line to whether any enabled request is pending. A device clear drops the line only when no enabled request remains.

Top module: `mirq_aggregator`

## Requirements
- R1: After a synchronous reset the pending vector, the enable mask, the second mask register and the interrupting flag are all zero, and `irq_o` is low. A read of the mask address (0) returns all ones, because the stored enable mask is zero.
- R2: A write to address 0 stores the bitwise inverse of `bus_wdata` as the enable mask, so a written 1 masks that request off. Reads of address 0 return the byte that was last written.
- R3: In a cycle with a mask write and no post, `irq_o` on the next cycle is 1 exactly when (pending after this cycle AND the new enable mask) is nonzero.
- R4: A write to address 2 clears pending bit `bus_wdata[3:0]` when that index is below REQ_W, and clears no bit when it is not. In either case `irq_o` is low on the next cycle unless a post arrives in the same cycle.
- R5: A nonzero `dev_post` ORs its bits into the pending vector and makes `irq_o` high on the next cycle, whatever the mask holds.
- R6: A nonzero `dev_clear` removes its bits from the pending vector. In a cycle with no post and no register write to address 0 or 2, `irq_o` drops only if no enabled request remains, and otherwise keeps its value.
- R7: When a post and a clear or an acknowledge name the same bit in the same cycle, the bit ends up set.
- R8: The read data register updates one cycle after the address is presented. Address 3 returns the pending vector as it stood before that clock edge.
- R9: Address 1 is a storage-only mask that reads back its last written value and never changes `irq_o`. Address 2, address 4 and the unmapped addresses (5 to 7) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| dev_post | input | REQ_W | Device request set bits |
| dev_clear | input | REQ_W | Device request clear bits |
| irq_o | output | 1 | Upstream interrupt line |

## Verification
The bench targets the cases where the flag must not simply follow the masked level:
- A post of a masked request must raise the line. A level-following design would leave the line low.
- A device clear while another enabled request is pending must keep the line high. A design that dropped the flag on any clear would lose the interrupt.
- An acknowledge with an index of REQ_W or above must drop the line without touching the pending vector. A design that wrapped the index would clear the wrong bit.

Post-versus-clear and post-versus-acknowledge collisions on one bit are driven on purpose; a design with the wrong priority would lose the request. Writes to the second mask register are placed while enabled requests are pending, to show that the line does not move. A random phase then mixes all of these events and compares the line and the read data against a bench model on every cycle.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int MIRQ_A_MASK   = 0;
  localparam int MIRQ_A_MASK_B = 1;
  localparam int MIRQ_A_ACK    = 2;
  localparam int MIRQ_A_STAT   = 3;
  localparam int MIRQ_A_STAT_B = 4;

  typedef struct packed {
    logic mask_a;
    logic mask_b;
    logic ack;
  } mirq_wr_t;
endpackage

// File: rtl/mirq_decode.sv
module mirq_decode
  import mirq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output mirq_wr_t          wr
);
  always_comb begin
    wr.mask_a = we && (addr == ADDR_W'(MIRQ_A_MASK));
    wr.mask_b = we && (addr == ADDR_W'(MIRQ_A_MASK_B));
    wr.ack    = we && (addr == ADDR_W'(MIRQ_A_ACK));
  end
endmodule

// File: rtl/mirq_regs.sv
module mirq_regs
  import mirq_pkg::*;
#(
  parameter int REQ_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mirq_wr_t          wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [REQ_W-1:0]  enable,
  output logic [REQ_W-1:0]  enable_nxt,
  output logic [DATA_W-1:0] mask_b
);
  logic [REQ_W-1:0] inv_w;
  assign inv_w      = REQ_W'(~wdata);
  assign enable_nxt = wr.mask_a ? inv_w : enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask_b <= '0;
    end else begin
      enable <= enable_nxt;
      if (wr.mask_b) mask_b <= wdata;
    end
  end

  assert_mask_inverse_R2: assert property (@(posedge clk) disable iff (rst)
    wr.mask_a |=> (enable == REQ_W'(~$past(wdata))));
  assert_maskb_store_R9: assert property (@(posedge clk) disable iff (rst)
    wr.mask_b |=> (mask_b == $past(wdata)));
endmodule

// File: rtl/mirq_pending.sv
module mirq_pending #(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_we,
  input  logic [3:0]       ack_idx,
  input  logic [REQ_W-1:0] post,
  input  logic [REQ_W-1:0] clr,
  output logic [REQ_W-1:0] pending,
  output logic [REQ_W-1:0] pending_nxt
);
  logic [REQ_W-1:0] ack_vec;

  generate
    for (genvar i = 0; i < REQ_W; i++) begin : g_ack
      assign ack_vec[i] = ack_we && (int'(ack_idx) == i);
    end
  endgenerate

  assign pending_nxt = (pending & ~clr & ~ack_vec) | post;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pending_nxt;
  end

  assert_post_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|post) |=> ((pending & $past(post)) == $past(post)));
  assert_clear_removes_R6: assert property (@(posedge clk) disable iff (rst)
    ((|clr) && !(|post)) |=> ((pending & $past(clr)) == '0));
endmodule

// File: rtl/mirq_line.sv
module mirq_line
  import mirq_pkg::*;
#(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mirq_wr_t         wr,
  input  logic [REQ_W-1:0] post,
  input  logic [REQ_W-1:0] clr,
  input  logic [REQ_W-1:0] pending_nxt,
  input  logic [REQ_W-1:0] enable_nxt,
  output logic             irq
);
  logic any_en;
  logic irq_nxt;

  assign any_en = |(pending_nxt & enable_nxt);

  always_comb begin
    irq_nxt = irq;
    if (|post)                irq_nxt = 1'b1;
    else if (wr.ack)          irq_nxt = 1'b0;
    else if (wr.mask_a)       irq_nxt = any_en;
    else if ((|clr) && !any_en) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_nxt;
  end

  assert_post_raises_R5: assert property (@(posedge clk) disable iff (rst)
    (|post) |=> irq);
  assert_ack_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (wr.ack && !(|post)) |=> !irq);
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((|post) || wr.mask_a));
  assert_fall_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr.ack || wr.mask_a || (|clr)));
  assert_maskb_inert_R9: assert property (@(posedge clk) disable iff (rst)
    (wr.mask_b && !(|post) && !(|clr)) |=> $stable(irq));
endmodule

// File: rtl/mirq_aggregator.sv
module mirq_aggregator
  import mirq_pkg::*;
#(
  parameter int REQ_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [REQ_W-1:0]  dev_post,
  input  logic [REQ_W-1:0]  dev_clear,
  output logic              irq_o
);
  mirq_wr_t         wr;
  logic [REQ_W-1:0] enable, enable_nxt, pending, pending_nxt;
  logic [DATA_W-1:0] mask_b;
  logic [DATA_W-1:0] rd_nxt;

  mirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .wr(wr));

  mirq_regs #(.REQ_W(REQ_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(wr), .wdata(bus_wdata),
    .enable(enable), .enable_nxt(enable_nxt), .mask_b(mask_b));

  mirq_pending #(.REQ_W(REQ_W)) u_pend (
    .clk(clk), .rst(rst), .ack_we(wr.ack), .ack_idx(bus_wdata[3:0]),
    .post(dev_post), .clr(dev_clear),
    .pending(pending), .pending_nxt(pending_nxt));

  mirq_line #(.REQ_W(REQ_W)) u_line (
    .clk(clk), .rst(rst), .wr(wr), .post(dev_post), .clr(dev_clear),
    .pending_nxt(pending_nxt), .enable_nxt(enable_nxt), .irq(irq_o));

  always_comb begin
    if (bus_addr == ADDR_W'(MIRQ_A_MASK))        rd_nxt = DATA_W'(~enable);
    else if (bus_addr == ADDR_W'(MIRQ_A_MASK_B)) rd_nxt = mask_b;
    else if (bus_addr == ADDR_W'(MIRQ_A_STAT))   rd_nxt = DATA_W'(pending);
    else                                         rd_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && (pending == '0) && (enable == '0)));
  assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(MIRQ_A_STAT)) |=> (bus_rdata == DATA_W'($past(pending))));
endmodule

// File: tb/mirq_aggregator_test.sv
module mirq_aggregator_test;
  localparam int REQ_W  = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [REQ_W-1:0]  dev_post = '0;
  logic [REQ_W-1:0]  dev_clear = '0;
  logic              irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [REQ_W-1:0]  m_pend = '0;
  logic [REQ_W-1:0]  m_en = '0;
  logic [DATA_W-1:0] m_mb = '0;
  logic              m_irq = 1'b0;

  always #5 clk = ~clk;

  mirq_aggregator #(.REQ_W(REQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_post(dev_post),
    .dev_clear(dev_clear), .irq_o(irq_o));

  function automatic logic [DATA_W-1:0] exp_read(logic [ADDR_W-1:0] a);
    case (a)
      3'd0: return DATA_W'(~m_en);
      3'd1: return m_mb;
      3'd3: return DATA_W'(m_pend);
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic [ADDR_W-1:0] a, logic we,
                       logic [DATA_W-1:0] wd, logic [REQ_W-1:0] p,
                       logic [REQ_W-1:0] c);
    logic [DATA_W-1:0] erd;
    logic [REQ_W-1:0]  ackv;
    logic [REQ_W-1:0]  pn;
    logic [REQ_W-1:0]  en;
    bus_addr = a; bus_we = we; bus_wdata = wd; dev_post = p; dev_clear = c;
    erd  = exp_read(a);
    ackv = '0;
    if (we && a == 3'd2 && int'(wd[3:0]) < REQ_W) ackv[wd[3:0]] = 1'b1;
    pn = (m_pend & ~c & ~ackv) | p;
    en = (we && a == 3'd0) ? REQ_W'(~wd) : m_en;
    if (p != '0) m_irq = 1'b1;
    else if (we && a == 3'd2) m_irq = 1'b0;
    else if (we && a == 3'd0) m_irq = ((pn & en) != '0);
    else if (c != '0 && (pn & en) == '0) m_irq = 1'b0;
    m_pend = pn;
    m_en = en;
    if (we && a == 3'd1) m_mb = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag, "irq_o", 32'(irq_o), 32'(m_irq));
    check(tag, "bus_rdata", 32'(bus_rdata), 32'(erd));
  endtask

  task automatic idle_read(string tag, logic [ADDR_W-1:0] a);
    cycle(tag, a, 1'b0, '0, '0, '0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "irq_o after reset", 32'(irq_o), 32'h0);
    idle_read("R1", 3'd0);
    idle_read("R1", 3'd3);
    idle_read("R1", 3'd1);

    // R5 masked post still raises, R8 status
    cycle("R5", 3'd3, 1'b0, '0, 8'h04, '0);
    idle_read("R8", 3'd3);
    // R4 acknowledge bit 2
    cycle("R4", 3'd2, 1'b1, 8'h02, '0, '0);
    idle_read("R4", 3'd3);
    // R2/R3 mask writes
    cycle("R2", 3'd0, 1'b1, 8'hFB, '0, '0);
    idle_read("R2", 3'd0);
    cycle("R5", 3'd0, 1'b0, '0, 8'h04, '0);
    cycle("R3", 3'd0, 1'b1, 8'hFF, '0, '0);
    cycle("R3", 3'd0, 1'b1, 8'hFB, '0, '0);
    // R6 clears
    cycle("R6", 3'd3, 1'b0, '0, 8'h20, '0);
    cycle("R6", 3'd3, 1'b0, '0, '0, 8'h20);
    cycle("R6", 3'd3, 1'b0, '0, '0, 8'h04);
    idle_read("R6", 3'd3);
    cycle("R6", 3'd3, 1'b0, '0, 8'h08, '0);
    cycle("R6", 3'd3, 1'b0, '0, '0, 8'h08);
    // R7 collisions
    cycle("R7", 3'd3, 1'b0, '0, 8'h02, 8'h02);
    idle_read("R7", 3'd3);
    cycle("R7", 3'd2, 1'b1, 8'h01, 8'h02, '0);
    idle_read("R7", 3'd3);
    // R4 out-of-range index
    cycle("R4", 3'd2, 1'b1, 8'h09, '0, '0);
    idle_read("R4", 3'd3);
    // R9 second mask inert, zero reads
    cycle("R9", 3'd0, 1'b1, 8'h00, '0, '0);
    cycle("R9", 3'd1, 1'b1, 8'h00, '0, '0);
    cycle("R9", 3'd1, 1'b1, 8'h5A, '0, '0);
    idle_read("R9", 3'd1);
    idle_read("R9", 3'd4);
    idle_read("R9", 3'd2);
    idle_read("R9", 3'd7);

    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      logic we;
      logic [DATA_W-1:0] wd;
      logic [REQ_W-1:0] p, c;
      a  = ADDR_W'($urandom_range(0, 7));
      we = ($urandom_range(0, 3) == 0);
      wd = DATA_W'($urandom);
      if (a == 3'd2) wd[3:0] = 4'($urandom_range(0, 10));
      p  = ($urandom_range(0, 4) == 0) ? REQ_W'(1 << $urandom_range(0, REQ_W-1)) : '0;
      c  = ($urandom_range(0, 2) == 0) ? REQ_W'($urandom) : '0;
      cycle("R3", a, we, wd, p, c);
    end
    finish_up();
  end
endmodule